// File: doc/BRIEF.md
# Floating-point to 32-bit integer converter

This block turns an IEEE-754 binary32 or binary64 operand into a 32-bit integer, either two's-complement signed or unsigned. The caller chooses the precision, the signedness, a 2-bit rounding mode and a per-operation truncate bit, then pulses `start` for one cycle. A fixed number of cycles later `valid` pulses once, together with the integer, an invalid-operation flag and an inexact flag. A new operation may start in every cycle.

Exceptions are never trapped. Every out-of-range or special operand produces a fixed saturation code. That code depends on the direction of the overflow and on the signedness of the result. NaN operands always give zero. The range check is made on the rounded value, so an operand that rounds to a representable extreme is still accepted.

Top module: `fp_to_int32`

## Requirements
- R1: `valid` goes high exactly `1 + OUT_STAGES` cycles after each cycle in which `start` is high, for one cycle per start, including back-to-back starts.
- R2: The rounding mode encoding is 00 to nearest with ties to even, 01 toward plus infinity, 10 toward minus infinity and 11 toward zero. The mode applies to the fraction that is discarded.
- R3: When `chop` is 1, the result is truncated toward zero whatever `rmode` holds.
- R4: For a signed result, plus infinity or a rounded value above 2^31-1 gives 0x7FFFFFFF with `invalid` set.
- R5: For a signed result, minus infinity or a rounded value below -2^31 gives 0x80000000 with `invalid` set.
- R6: For an unsigned result, minus infinity or a negative rounded value gives 0x00000000 with `invalid` set. A negative operand that rounds to zero gives 0 without `invalid`.
- R7: For an unsigned result, plus infinity or a rounded value above 2^32-1 gives 0xFFFFFFFF with `invalid` set.
- R8: Any NaN gives 0x00000000 with `invalid` set, for both signed and unsigned results.
- R9: `inexact` is 1 exactly when a nonzero fraction was discarded and `invalid` is 0. It is never set together with `invalid`.
- R10: A subnormal operand gives 0 with `inexact` set. Under a directed mode that rounds away from zero it gives +1 or -1 instead.
- R11: The range check applies after rounding. Values that round to exactly 2^31-1, -2^31 or 2^32-1 are returned without `invalid`.
- R12: With `dbl` = 0 the operand is `op[31:0]` (sign bit 31, exponent bits 30:23, fraction bits 22:0) and `op[63:32]` is ignored. With `dbl` = 1 the operand uses all 64 bits (sign 63, exponent 62:52, fraction 51:0).
- R13: After reset, and in every cycle where `valid` is 0, `result`, `invalid` and `inexact` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion of the current inputs |
| op | input | 64 | Operand bits (binary32 in the low half when dbl is 0) |
| dbl | input | 1 | 1 selects binary64, 0 selects binary32 |
| to_signed | input | 1 | 1 for a signed result, 0 for unsigned |
| chop | input | 1 | Force truncation toward zero |
| rmode | input | 2 | Rounding mode |
| valid | output | 1 | Result strobe |
| result | output | 32 | Integer result |
| invalid | output | 1 | Invalid-operation flag |
| inexact | output | 1 | Inexact flag |

## Verification
The bench builds the converter with the default `OUT_STAGES` = 1, which gives a two-cycle latency. It issues some starts back to back and some with idle gaps between them, so that both overlapping and isolated results are checked against the latency rule. Directed operands cover every rounding mode on the ties, both signed and unsigned saturation edges before and after rounding, NaNs, infinities, signed zeros and subnormals in both precisions. Several thousand pseudo-random operands then have their exponents steered around the 2^31 and 2^32 boundaries.

// File: rtl/fp_to_int32.sv
module fp_to_int32 #(
  parameter int OUT_STAGES = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] op,
  input  logic        dbl,
  input  logic        to_signed,
  input  logic        chop,
  input  logic [1:0]  rmode,
  output logic        valid,
  output logic [31:0] result,
  output logic        invalid,
  output logic        inexact
);
  localparam int IW = 32;
  localparam int PW = IW + 1;
  localparam int MW = 34;
  localparam int RW = IW + 3;
  localparam logic [1:0] RM_NE = 2'd0;
  localparam logic [1:0] RM_UP = 2'd1;
  localparam logic [1:0] RM_DN = 2'd2;
  localparam logic [1:0] RM_ZR = 2'd3;
  localparam logic [IW-1:0] S_POS = 32'h7FFF_FFFF;
  localparam logic [IW-1:0] S_NEG = 32'h8000_0000;
  localparam logic [IW-1:0] U_MAX = 32'hFFFF_FFFF;

  logic        s_vld, s_dbl, s_sig;
  logic [63:0] s_op;
  logic [1:0]  s_rm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_vld <= 1'b0;
      s_op  <= '0;
      s_dbl <= 1'b0;
      s_sig <= 1'b0;
      s_rm  <= RM_NE;
    end else begin
      s_vld <= start;
      if (start) begin
        s_op  <= op;
        s_dbl <= dbl;
        s_sig <= to_signed;
        s_rm  <= chop ? RM_ZR : rmode;
      end
    end
  end

  logic               neg, emax, fr_nz;
  logic [10:0]        ef;
  logic [51:0]        fr;
  logic signed [12:0] e;
  logic [85:0]        wide;

  assign neg   = s_dbl ? s_op[63] : s_op[31];
  assign ef    = s_dbl ? s_op[62:52] : {3'b000, s_op[30:23]};
  assign fr    = s_dbl ? s_op[51:0] : {s_op[22:0], 29'd0};
  assign emax  = s_dbl ? (&s_op[62:52]) : (&s_op[30:23]);
  assign fr_nz = |fr;
  assign e     = $signed({2'b00, ef}) - (s_dbl ? 13'sd1023 : 13'sd127);
  assign wide  = {33'd0, 1'b1, fr} << e[5:0];

  logic [PW-1:0] ip;
  logic          g, st, huge;

  always_comb begin
    ip   = '0;
    g    = 1'b0;
    st   = 1'b0;
    huge = 1'b0;
    if (emax) begin
      huge = 1'b0;
    end else if (ef == 11'd0) begin
      st = fr_nz;
    end else if (e < 13'sd0) begin
      g  = (e == -13'sd1);
      st = (e == -13'sd1) ? fr_nz : 1'b1;
    end else if (e > 13'sd32) begin
      huge = 1'b1;
    end else begin
      ip = wide[84:52];
      g  = wide[51];
      st = |wide[50:0];
    end
  end

  logic          inc;
  logic [MW-1:0] mag;

  always_comb begin
    case (s_rm)
      RM_NE:   inc = g & (st | ip[0]);
      RM_UP:   inc = ~neg & (g | st);
      RM_DN:   inc = neg & (g | st);
      default: inc = 1'b0;
    endcase
  end

  assign mag = {1'b0, ip} + MW'(inc);

  logic          is_nan, ovf;
  logic [IW-1:0] r_res;
  logic          r_inv, r_inx;

  assign is_nan = emax & fr_nz;
  assign ovf    = emax | huge;

  always_comb begin
    r_res = '0;
    r_inv = 1'b0;
    if (is_nan) begin
      r_inv = 1'b1;
    end else if (s_sig) begin
      if (neg) begin
        if (ovf || mag > MW'(34'h0_8000_0000)) begin
          r_inv = 1'b1;
          r_res = S_NEG;
        end else begin
          r_res = -mag[IW-1:0];
        end
      end else begin
        if (ovf || mag > MW'(34'h0_7FFF_FFFF)) begin
          r_inv = 1'b1;
          r_res = S_POS;
        end else begin
          r_res = mag[IW-1:0];
        end
      end
    end else begin
      if (neg) begin
        if (ovf || mag != '0) r_inv = 1'b1;
      end else if (ovf || mag > MW'(34'h0_FFFF_FFFF)) begin
        r_inv = 1'b1;
        r_res = U_MAX;
      end else begin
        r_res = mag[IW-1:0];
      end
    end
    r_inx = ~r_inv & (g | st);
  end

  logic [RW-1:0] pipe [OUT_STAGES];

  generate
    for (genvar k = 0; k < OUT_STAGES; k++) begin : g_out
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[k] <= '0;
        else if (k == 0) pipe[k] <= s_vld ? {1'b1, r_inv, r_inx, r_res} : '0;
        else pipe[k] <= pipe[(k == 0) ? 0 : k-1];
      end
    end
  endgenerate

  assign valid   = pipe[OUT_STAGES-1][RW-1];
  assign invalid = pipe[OUT_STAGES-1][RW-2];
  assign inexact = pipe[OUT_STAGES-1][RW-3];
  assign result  = pipe[OUT_STAGES-1][IW-1:0];
endmodule

// File: rtl/fp_to_int32_chk.sv
module fp_to_int32_chk #(
  parameter int OUT_STAGES = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [63:0] op,
  input logic        dbl,
  input logic        valid,
  input logic [31:0] result,
  input logic        invalid,
  input logic        inexact
);
  localparam int LAT = OUT_STAGES + 1;

  logic [LAT-1:0] st_sh, nan_sh;
  logic           nan_in;

  assign nan_in = dbl ? ((&op[62:52]) & (|op[51:0])) : ((&op[30:23]) & (|op[22:0]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_sh  <= '0;
      nan_sh <= '0;
    end else begin
      st_sh  <= {st_sh[LAT-2:0], start};
      nan_sh <= {nan_sh[LAT-2:0], start & nan_in};
    end
  end

  a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    valid == st_sh[LAT-1]);

  a_r8_nan_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && nan_sh[LAT-1]) |-> (invalid && result == 32'h0));

  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !(invalid && inexact));

  a_r4_saturation_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && invalid) |-> (result == 32'h0 || result == 32'h7FFF_FFFF ||
                            result == 32'h8000_0000 || result == 32'hFFFF_FFFF));

  a_r13_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (result == 32'h0 && !invalid && !inexact));
endmodule

bind fp_to_int32 fp_to_int32_chk #(.OUT_STAGES(OUT_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .dbl(dbl),
  .valid(valid), .result(result), .invalid(invalid), .inexact(inexact)
);

// File: tb/fp_to_int32_tb_top.sv
module fp_to_int32_tb_top;
  localparam int OUT_STAGES = 1;
  localparam int LAT = OUT_STAGES + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] op = '0;
  logic        dbl = 1'b0, to_signed = 1'b0, chop = 1'b0;
  logic [1:0]  rmode = 2'd0;
  logic        valid, invalid, inexact;
  logic [31:0] result;

  fp_to_int32 #(.OUT_STAGES(OUT_STAGES)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .dbl(dbl),
    .to_signed(to_signed), .chop(chop), .rmode(rmode),
    .valid(valid), .result(result), .invalid(invalid), .inexact(inexact)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int          q_due[$];
  logic [33:0] q_exp[$];
  string       q_tag[$];

  function automatic real p2(int k);
    real r = 1.0;
    if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
    else for (int i = 0; i < -k; i++) r = r / 2.0;
    return r;
  endfunction

  function automatic logic [33:0] ref_conv(logic [63:0] v, bit d, bit sg, bit ch, logic [1:0] rm);
    bit ng, big, inv, inx, up;
    int ex, bias, fw, emx, m;
    longint frq, n, val;
    real a, fl, fp;
    logic [31:0] res;
    big = 0; inv = 0; res = 0; a = 0.0;
    if (d) begin ng = v[63]; ex = int'(v[62:52]); frq = longint'(v[51:0]); bias = 1023; fw = 52; emx = 2047; end
    else   begin ng = v[31]; ex = int'(v[30:23]); frq = longint'(v[22:0]); bias = 127;  fw = 23; emx = 255;  end
    if (ex == emx) begin
      if (frq != 0) return {1'b1, 1'b0, 32'h0};
      big = 1;
    end else if (ex == 0) a = real'(frq) * p2(1 - bias - fw);
    else a = (real'(frq) + p2(fw)) * p2(ex - bias - fw);
    if (!big && a >= p2(34)) big = 1;
    n = 0; fp = 0.0;
    if (!big) begin
      fl = $floor(a);
      fp = a - fl;
      n = longint'(fl);
      m = ch ? 3 : int'(rm);
      case (m)
        0: up = (fp > 0.5) || (fp == 0.5 && n[0]);
        1: up = !ng && fp > 0.0;
        2: up = ng && fp > 0.0;
        default: up = 0;
      endcase
      if (up) n = n + 1;
    end
    val = ng ? -n : n;
    if (sg) begin
      if (big) begin inv = 1; res = ng ? 32'h8000_0000 : 32'h7FFF_FFFF; end
      else if (val > 64'sd2147483647) begin inv = 1; res = 32'h7FFF_FFFF; end
      else if (val < -64'sd2147483648) begin inv = 1; res = 32'h8000_0000; end
      else res = val[31:0];
    end else begin
      if ((big && ng) || val < 0) begin inv = 1; res = 32'h0; end
      else if (big || val > 64'sd4294967295) begin inv = 1; res = 32'hFFFF_FFFF; end
      else res = val[31:0];
    end
    inx = !big && fp != 0.0 && !inv;
    return {inv, inx, res};
  endfunction

  task automatic fail(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_bad++;
    $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
  endtask

  task automatic step();
    bit ev;
    logic [33:0] x;
    string t;
    @(negedge clk);
    ev = q_due.size() > 0 && q_due[0] == cyc;
    n_chk++;
    if (valid !== ev) fail("R1", "valid", {31'd0, valid}, {31'd0, ev});
    if (ev) begin
      x = q_exp.pop_front();
      t = q_tag.pop_front();
      void'(q_due.pop_front());
      if (result !== x[31:0]) fail(t, "result", result, x[31:0]);
      if (invalid !== x[33]) fail(t, "invalid", {31'd0, invalid}, {31'd0, x[33]});
      if (inexact !== x[32]) fail(t, "inexact(R9)", {31'd0, inexact}, {31'd0, x[32]});
    end else if (result !== 32'h0 || invalid !== 1'b0 || inexact !== 1'b0) begin
      fail("R13", "idle outputs", result, 32'h0);
    end
    start = 1'b0;
  endtask

  task automatic send(logic [63:0] v, bit d, bit sg, bit ch, logic [1:0] rm, string tag);
    step();
    start = 1'b1; op = v; dbl = d; to_signed = sg; chop = ch; rmode = rm;
    q_due.push_back(cyc + LAT);
    q_exp.push_back(ref_conv(v, d, sg, ch, rm));
    q_tag.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    idle(1);
    rst_n = 1'b1;
    idle(2);
    // R2 rounding modes on ties
    send(64'h3FC00000, 0, 1, 0, 2'd0, "R2");
    send(64'h3FC00000, 0, 1, 0, 2'd1, "R2");
    send(64'h3FC00000, 0, 1, 0, 2'd2, "R2");
    send(64'h3FC00000, 0, 1, 0, 2'd3, "R2");
    send(64'h40200000, 0, 1, 0, 2'd0, "R2");
    send(64'hBFC00000, 0, 1, 0, 2'd2, "R2");
    send(64'hBFC00000, 0, 1, 0, 2'd1, "R2");
    idle(3);
    // R3 truncate override
    send(64'h3FC00000, 0, 1, 1, 2'd0, "R3");
    send(64'hBFC00000, 0, 1, 1, 2'd2, "R3");
    send(64'h3FC00000, 0, 0, 1, 2'd1, "R3");
    // R4 R5 R6 R7 saturation
    send(64'h4F000000, 0, 1, 0, 2'd0, "R4");
    send(64'h7F800000, 0, 1, 0, 2'd0, "R4");
    send(64'hFF800000, 0, 1, 0, 2'd0, "R5");
    send(64'hCF000001, 0, 1, 0, 2'd0, "R5");
    send(64'hFF800000, 0, 0, 0, 2'd0, "R6");
    send(64'hBE800000, 0, 0, 0, 2'd3, "R6");
    send(64'hBE800000, 0, 0, 0, 2'd2, "R6");
    send(64'h7F800000, 0, 0, 0, 2'd0, "R7");
    send(64'h4F800000, 0, 0, 0, 2'd0, "R7");
    send(64'h4F7FFFFF, 0, 0, 0, 2'd0, "R7");
    idle(2);
    // R8 NaNs
    send(64'h7FC00000, 0, 1, 0, 2'd0, "R8");
    send(64'hFF800001, 0, 0, 0, 2'd0, "R8");
    send(64'h7FF8000000000000, 1, 1, 0, 2'd0, "R8");
    send(64'hFFF0000000000001, 1, 0, 0, 2'd1, "R8");
    // R10 subnormals, zeros
    send(64'h00000001, 0, 1, 0, 2'd0, "R10");
    send(64'h00000001, 0, 1, 0, 2'd1, "R10");
    send(64'h80000001, 0, 1, 0, 2'd2, "R10");
    send(64'h0000000000000001, 1, 0, 0, 2'd1, "R10");
    send(64'h80000000, 0, 1, 0, 2'd1, "R9");
    send(64'h8000000000000000, 1, 0, 0, 2'd2, "R9");
    // R11 rounding at the boundary
    send(64'h41DFFFFFFFE00000, 1, 1, 0, 2'd3, "R11");
    send(64'h41DFFFFFFFE00000, 1, 1, 0, 2'd0, "R11");
    send(64'hC1E0000000200000, 1, 1, 0, 2'd0, "R11");
    send(64'hC1E0000000200000, 1, 1, 0, 2'd2, "R11");
    send(64'hCF000000, 0, 1, 0, 2'd0, "R11");
    send(64'h4F000000, 0, 0, 0, 2'd0, "R11");
    send(64'h41EFFFFFFFF00000, 1, 0, 0, 2'd3, "R11");
    send(64'h41EFFFFFFFF00000, 1, 0, 0, 2'd0, "R11");
    // R12 precision select
    send(64'hDEADBEEF_3FC00000, 0, 1, 0, 2'd0, "R12");
    send(64'h3FF8000000000000, 1, 1, 0, 2'd0, "R12");
    send(64'hFFFFFFFF_C0490FDB, 0, 1, 0, 2'd0, "R12");
    idle(4);
    // random sweep, mixed gaps
    for (int i = 0; i < 4000; i++) begin
      logic [63:0] v;
      bit d;
      v = {$urandom(), $urandom()};
      d = $urandom() % 2;
      if ($urandom() % 8 != 0) begin
        if (d) v[62:52] = 11'(1000 + $urandom() % 70);
        else   v[30:23] = 8'(110 + $urandom() % 50);
      end
      if ($urandom() % 4 == 0) v[31:0] = v[31:0] & 32'hFFF0_0000;
      send(v, d, 1'($urandom()), ($urandom() % 6) == 0, 2'($urandom()), "R2");
      if ($urandom() % 5 == 0) idle(1);
    end
    idle(LAT + 3);
    if (q_due.size() != 0) fail("R1", "missing results", q_due.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule